// File: doc/BRIEF.md
# SCSI Bus Phase Guard and Exception Reporter

This block watches the control lines of a SCSI bus on behalf of an initiator-side sequencer. The host issues a 4-bit command code. The block tracks whether it owns the bus, whether a target is connected, and which information-transfer phase the pending command expects. When the target raises REQ, the block compares the phase the target presents with that expectation. A matching phase completes the command with a one-cycle done pulse. Any other phase aborts the command and records a phase mismatch.

Events are sorted into two status registers, one for exceptions and one for errors. These feed a three-source interrupt register with a mask and a single interrupt line. A selection timer counts ticks of an external 10 ms timebase. The host clears status bits by writing ones. Data movement, the byte FIFO, DMA and electrical bus timing are handled elsewhere.

Top module: `scsi_phase_guard`

## Requirements
- R1: Transfer codes and the phase each expects, with phase = {MSG,C/D,I/O}: command 3 expects 2, status 4 expects 3, data-out 5 expects 0, data-in 6 expects 1, message-out 7 expects 6, message-in 8 expects 7. When REQ is seen with the expected phase, the command completes. The block then pulses cmd_done for one cycle and sets int_reg bit 0.
- R2: When REQ is seen during a transfer command with any other phase, exc_reg bit 1 (0x02) is set. No done is produced, and the command is dropped so that the next command is accepted.
- R3: Arbitrate (1) with BSY or SEL high sets exc_reg bit 2 (0x04). Otherwise it completes with done and the bus becomes owned.
- R4: Select (2) on an owned bus waits for BSY. BSY high completes the command with done and marks the target connected.
- R5: While a select waits with a timeout value T other than 0, the T-th tick sets exc_reg bit 0 (0x01), gives no done, and releases the bus. With T=0 the select never times out.
- R6: err_reg bit 4 (0x10) is set by each of the following: code 0; any command other than 0xE while one is pending; arbitrate when the bus is owned or a target is connected; select without ownership; codes 3 to 9 with no target connected.
- R7: Bus-free (9) completes with done when BSY drops. BSY dropping while connected at any other time sets err_reg bit 6 (0x40) and ends the connection.
- R8: RST high sets err_reg bit 5 (0x20) and drops ownership, the connection and any pending command. A parity strobe sets err_reg bit 0 (0x01) only while parity checking is on. Code 0xA turns checking on, code 0xB turns it off, and it is off after reset.
- R9: After code 0xC, and before code 0xD, SEL with I/O high while the bus is neither owned nor connected sets exc_reg bit 3 (0x08) and connects the target. exc_reg bits 5 and 4 always read 0.
- R10: int_reg bit 2 is set while err_reg is nonzero, and bit 1 while exc_reg is nonzero. Bit 0 is the sticky done flag. irq is the OR of int_reg AND the mask.
- R11: A register write with csr_addr 0, 1 or 2 clears the exc_reg, err_reg or int_reg bit 0 bits that are written as ones. csr_addr 3 loads the 3-bit mask. A bit set in the same cycle stays set.
- R12: Code 0xE clears exc_reg, err_reg, the done flag, the timer, ownership, the connection and the parity and reselect enables. The mask is kept. Codes 0xA to 0xD and 0xF complete with done.
- R13: After reset all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command code strobe |
| cmd_code | input | 4 | Sequencer command code |
| bus_req | input | 1 | Sampled REQ |
| bus_ack | input | 1 | Sampled ACK (observed only) |
| bus_atn | input | 1 | Sampled ATN (observed only) |
| bus_msg | input | 1 | Sampled MSG, phase bit 2 |
| bus_cd | input | 1 | Sampled C/D, phase bit 1 |
| bus_io | input | 1 | Sampled I/O, phase bit 0 |
| bus_rst | input | 1 | Sampled RST |
| bus_bsy | input | 1 | Sampled BSY |
| bus_sel | input | 1 | Sampled SEL |
| parity_err | input | 1 | Parity error strobe |
| tick_10ms | input | 1 | Timebase tick, one cycle per 10 ms |
| sel_timeout | input | TO_W | Selection timeout in ticks, 0 disables |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | 0 exc clear, 1 err clear, 2 int clear, 3 mask |
| csr_wdata | input | 8 | Register write data |
| exc_reg | output | 8 | Exception register |
| err_reg | output | 8 | Error register |
| int_reg | output | 3 | Interrupt register |
| mask_reg | output | 3 | Interrupt mask |
| irq | output | 1 | Masked interrupt line |
| cmd_done | output | 1 | One-cycle command completion pulse |

## Verification
The bench builds the block with TO_W=4. This makes it cheap to sweep every timeout value from 0 to 15 and check that the exception lands exactly on the T-th tick. The six transfer codes are crossed with all eight phases, which gives every match and mismatch pair. All eight mask values are crossed with all eight combinations of active interrupt sources.

// File: rtl/scsi_phase_guard.sv
module scsi_phase_guard #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_code,
  input  logic            bus_req,
  input  logic            bus_ack,
  input  logic            bus_atn,
  input  logic            bus_msg,
  input  logic            bus_cd,
  input  logic            bus_io,
  input  logic            bus_rst,
  input  logic            bus_bsy,
  input  logic            bus_sel,
  input  logic            parity_err,
  input  logic            tick_10ms,
  input  logic [TO_W-1:0] sel_timeout,
  input  logic            csr_we,
  input  logic [1:0]      csr_addr,
  input  logic [7:0]      csr_wdata,
  output logic [7:0]      exc_reg,
  output logic [7:0]      err_reg,
  output logic [2:0]      int_reg,
  output logic [2:0]      mask_reg,
  output logic            irq,
  output logic            cmd_done
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_XFER, ST_BFREE} st_t;

  st_t             st, st_n;
  logic            owned, owned_n, conn, conn_n;
  logic            par_en, par_n, resel_en, resel_n;
  logic [2:0]      exp_ph, exp_n;
  logic [TO_W-1:0] tcnt, tcnt_n;
  logic [TO_W:0]   tinc;
  logic [5:0]      exc_q, exc_set, exc_clr;
  logic [6:0]      err_q, err_set, err_clr;
  logic            done_q, done_set, done_clr, done_p;
  logic [2:0]      mask_q;
  logic            clr_all;
  logic [2:0]      phase;

  assign phase = {bus_msg, bus_cd, bus_io};
  assign tinc  = {1'b0, tcnt} + 1'b1;

  function automatic logic [2:0] want_phase(input logic [3:0] c);
    case (c)
      4'd3:    want_phase = 3'd2;
      4'd4:    want_phase = 3'd3;
      4'd5:    want_phase = 3'd0;
      4'd6:    want_phase = 3'd1;
      4'd7:    want_phase = 3'd6;
      default: want_phase = 3'd7;
    endcase
  endfunction

  always_comb begin
    st_n = st; owned_n = owned; conn_n = conn; par_n = par_en; resel_n = resel_en;
    exp_n = exp_ph; tcnt_n = tcnt;
    exc_set = '0; err_set = '0; done_set = 1'b0; clr_all = 1'b0;
    if (cmd_valid && cmd_code == 4'hE) begin
      clr_all = 1'b1; st_n = ST_IDLE; owned_n = 1'b0; conn_n = 1'b0;
      par_n = 1'b0; resel_n = 1'b0; tcnt_n = '0;
    end else if (bus_rst) begin
      err_set[5] = 1'b1; st_n = ST_IDLE; owned_n = 1'b0; conn_n = 1'b0; tcnt_n = '0;
    end else begin
      if (parity_err && par_en) err_set[0] = 1'b1;
      case (st)
        ST_SEL: begin
          if (bus_bsy) begin
            st_n = ST_IDLE; conn_n = 1'b1; owned_n = 1'b0; done_set = 1'b1; tcnt_n = '0;
          end else if (tick_10ms && sel_timeout != '0) begin
            if (tinc >= {1'b0, sel_timeout}) begin
              exc_set[0] = 1'b1; st_n = ST_IDLE; owned_n = 1'b0; tcnt_n = '0;
            end else begin
              tcnt_n = tinc[TO_W-1:0];
            end
          end
        end
        ST_XFER: begin
          if (!bus_bsy) begin
            err_set[6] = 1'b1; st_n = ST_IDLE; conn_n = 1'b0;
          end else if (bus_req) begin
            st_n = ST_IDLE;
            if (phase == exp_ph) done_set = 1'b1;
            else                 exc_set[1] = 1'b1;
          end
        end
        ST_BFREE: begin
          if (!bus_bsy) begin
            done_set = 1'b1; st_n = ST_IDLE; conn_n = 1'b0;
          end
        end
        default: begin
          if (conn && !bus_bsy) begin
            err_set[6] = 1'b1; conn_n = 1'b0;
          end else if (!conn && !owned && resel_en && bus_sel && bus_io) begin
            exc_set[3] = 1'b1; conn_n = 1'b1;
          end
        end
      endcase
      if (cmd_valid) begin
        if (st != ST_IDLE || cmd_code == 4'h0) begin
          err_set[4] = 1'b1;
        end else begin
          case (cmd_code)
            4'h1: begin
              if (owned || conn)           err_set[4] = 1'b1;
              else if (bus_bsy || bus_sel) exc_set[2] = 1'b1;
              else begin owned_n = 1'b1; done_set = 1'b1; end
            end
            4'h2: begin
              if (!owned || conn) err_set[4] = 1'b1;
              else begin st_n = ST_SEL; tcnt_n = '0; end
            end
            4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8: begin
              if (!conn) err_set[4] = 1'b1;
              else begin st_n = ST_XFER; exp_n = want_phase(cmd_code); end
            end
            4'h9: begin
              if (!conn) err_set[4] = 1'b1;
              else st_n = ST_BFREE;
            end
            4'hA: begin par_n = 1'b1;   done_set = 1'b1; end
            4'hB: begin par_n = 1'b0;   done_set = 1'b1; end
            4'hC: begin resel_n = 1'b1; done_set = 1'b1; end
            4'hD: begin resel_n = 1'b0; done_set = 1'b1; end
            default: done_set = 1'b1;
          endcase
        end
      end
    end
  end

  assign exc_clr  = (csr_we && csr_addr == 2'd0) ? csr_wdata[5:0] : '0;
  assign err_clr  = (csr_we && csr_addr == 2'd1) ? csr_wdata[6:0] : '0;
  assign done_clr = csr_we && csr_addr == 2'd2 && csr_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; owned <= 1'b0; conn <= 1'b0; par_en <= 1'b0; resel_en <= 1'b0;
      exp_ph <= '0; tcnt <= '0; exc_q <= '0; err_q <= '0; done_q <= 1'b0;
      done_p <= 1'b0; mask_q <= '0;
    end else begin
      st <= st_n; owned <= owned_n; conn <= conn_n; par_en <= par_n; resel_en <= resel_n;
      exp_ph <= exp_n; tcnt <= tcnt_n;
      done_p <= done_set;
      if (clr_all) begin
        exc_q <= '0; err_q <= '0; done_q <= 1'b0;
      end else begin
        exc_q  <= (exc_q & ~exc_clr) | exc_set;
        err_q  <= (err_q & ~err_clr) | err_set;
        done_q <= (done_q & ~done_clr) | done_set;
      end
      if (csr_we && csr_addr == 2'd3) mask_q <= csr_wdata[2:0];
    end
  end

  assign exc_reg  = {2'b00, exc_q & 6'b001111};
  assign err_reg  = {1'b0, err_q};
  assign int_reg  = {|err_q, |exc_q, done_q};
  assign mask_reg = mask_q;
  assign irq      = |(int_reg & mask_q);
  assign cmd_done = done_p;

  assert_mismatch_nodone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_q[1]) |-> !done_p);

  assert_timeout_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_q[0]) |-> ($past(st) == ST_SEL && $past(sel_timeout) != '0 && $past(tick_10ms)));

  assert_seqerr_code0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'h0 && !bus_rst) |=> err_q[4]);

  assert_busreset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !(cmd_valid && cmd_code == 4'hE)) |=> (err_q[5] && !conn && st == ST_IDLE));

  assert_ctlreset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'hE) |=> (exc_q == '0 && err_q == '0 && !done_q && !conn));

endmodule

// File: tb/scsi_phase_guard_test.sv
module scsi_phase_guard_test;
  localparam int TO_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0; logic [3:0] cmd_code = '0;
  logic bus_req = 0, bus_ack = 0, bus_atn = 0, bus_msg = 0, bus_cd = 0, bus_io = 0;
  logic bus_rst = 0, bus_bsy = 0, bus_sel = 0, parity_err = 0, tick_10ms = 0;
  logic [TO_W-1:0] sel_timeout = '0;
  logic csr_we = 0; logic [1:0] csr_addr = '0; logic [7:0] csr_wdata = '0;
  logic [7:0] exc_reg, err_reg; logic [2:0] int_reg, mask_reg; logic irq, cmd_done;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scsi_phase_guard #(.TO_W(TO_W)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic csr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic connect();
    bus_bsy = 0; bus_sel = 0;
    cmd(4'h1); chk("R3 arbitrate done", cmd_done, 1);
    cmd(4'h2); chk("R4 select pending", cmd_done, 0);
    bus_bsy = 1; step(); chk("R4 select done on BSY", cmd_done, 1);
  endtask

  function automatic logic [2:0] want(input int c);
    case (c) 3: want = 2; 4: want = 3; 5: want = 0; 6: want = 1; 7: want = 6; default: want = 7; endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; step();
    chk("R13 exc reset", exc_reg, 0); chk("R13 err reset", err_reg, 0);
    chk("R13 int reset", int_reg, 0); chk("R13 irq reset", irq, 0); chk("R13 mask reset", mask_reg, 0);

    // R1/R2 sweep: six transfer codes against every phase
    connect();
    for (int c = 3; c <= 8; c++) begin
      for (int ph = 0; ph < 8; ph++) begin
        cmd(c[3:0]); chk("R1 no early done", cmd_done, 0);
        {bus_msg, bus_cd, bus_io} = ph[2:0]; bus_req = 1; step();
        chk((ph[2:0] == want(c)) ? "R1 match done" : "R2 mismatch no done", cmd_done, ph[2:0] == want(c));
        chk("R2 mismatch bit", exc_reg[1], ph[2:0] != want(c));
        bus_req = 0;
        if (ph[2:0] == want(c)) chk("R1 int done bit", int_reg[0], 1);
        csr(2'd0, 8'hFF); csr(2'd2, 8'h01);
        chk("R11 exc cleared", exc_reg, 0); chk("R11 done cleared", int_reg[0], 0);
      end
    end

    // R7 bus free then unexpected disconnect
    cmd(4'h9); chk("R7 busfree waits", cmd_done, 0);
    bus_bsy = 0; step(); chk("R7 busfree done", cmd_done, 1);
    step(); chk("R7 no disconnect err after busfree", err_reg[6], 0);
    connect(); bus_bsy = 0; step(); step();
    chk("R7 unexpected disconnect", err_reg[6], 1);
    cmd(4'h3); chk("R6 xfer while disconnected", err_reg[4], 1);

    // R12 control reset keeps mask
    csr(2'd3, 8'h05);
    cmd(4'hE);
    chk("R12 exc clear", exc_reg, 0); chk("R12 err clear", err_reg, 0);
    chk("R12 int clear", int_reg, 0); chk("R12 mask kept", mask_reg, 5);
    cmd(4'hF); chk("R12 flush done", cmd_done, 1);

    // R3 arbitration lost
    cmd(4'hE); bus_bsy = 1; cmd(4'h1);
    chk("R3 lost on BSY", exc_reg[2], 1); chk("R3 no done", cmd_done, 0);
    bus_bsy = 0; cmd(4'hE); bus_sel = 1; cmd(4'h1);
    chk("R3 lost on SEL", exc_reg[2], 1); bus_sel = 0;

    // R6 sequence errors
    cmd(4'hE); cmd(4'h2); chk("R6 select without ownership", err_reg[4], 1);
    cmd(4'hE); cmd(4'h0); chk("R6 code zero", err_reg[4], 1);
    cmd(4'hE); cmd(4'h1); cmd(4'h1); chk("R6 arbitrate twice", err_reg[4], 1);
    cmd(4'hE); cmd(4'h1); cmd(4'h2); cmd(4'hF);
    chk("R6 command while pending", err_reg[4], 1); chk("R6 no done", cmd_done, 0);

    // R5 timeout sweep
    for (int t = 0; t < 16; t++) begin
      cmd(4'hE); sel_timeout = t[TO_W-1:0]; bus_bsy = 0;
      cmd(4'h1); cmd(4'h2);
      for (int k = 1; k <= ((t == 0) ? 20 : t); k++) begin
        chk("R5 no early timeout", exc_reg[0], 0);
        @(negedge clk); tick_10ms = 1; @(negedge clk); tick_10ms = 0;
      end
      if (t == 0) begin
        chk("R5 zero disables", exc_reg[0], 0);
        bus_bsy = 1; step(); chk("R5 late BSY still completes", cmd_done, 1);
      end else begin
        chk("R5 timeout at T ticks", exc_reg[0], 1); chk("R5 timeout no done", cmd_done, 0);
        cmd(4'h1); chk("R5 bus released", cmd_done, 1);
      end
    end
    bus_bsy = 0;

    // R8 bus reset and parity
    cmd(4'hE); connect();
    bus_rst = 1; step(); bus_rst = 0; bus_bsy = 0; step();
    chk("R8 bus reset err", err_reg[5], 1);
    cmd(4'h3); chk("R8 connection dropped", err_reg[4], 1);
    cmd(4'hE);
    @(negedge clk); parity_err = 1; @(negedge clk); parity_err = 0;
    chk("R8 parity off after reset", err_reg[0], 0);
    cmd(4'hA); chk("R12 parity enable done", cmd_done, 1);
    @(negedge clk); parity_err = 1; @(negedge clk); parity_err = 0;
    chk("R8 parity seen when on", err_reg[0], 1);
    csr(2'd1, 8'h01); cmd(4'hB);
    @(negedge clk); parity_err = 1; @(negedge clk); parity_err = 0;
    chk("R8 parity ignored when off", err_reg[0], 0);

    // R9 reselection
    cmd(4'hE); cmd(4'hC); chk("R12 resel enable done", cmd_done, 1);
    bus_sel = 1; bus_io = 1; bus_bsy = 1; step(); step();
    chk("R9 reselected", exc_reg[3], 1); chk("R9 target bits zero", exc_reg[5:4], 0);
    bus_sel = 0; {bus_msg, bus_cd, bus_io} = 3'd2;
    cmd(4'h3); bus_req = 1; step(); chk("R9 connected after resel", cmd_done, 1); bus_req = 0;
    cmd(4'hE); bus_bsy = 0; cmd(4'hC); cmd(4'hD);
    bus_sel = 1; bus_io = 1; bus_bsy = 1; step(); step();
    chk("R9 disabled resel ignored", exc_reg[3], 0);
    bus_sel = 0; bus_io = 0; bus_bsy = 0;

    // R10 irq sweep over sources and masks
    for (int s = 0; s < 8; s++) begin
      cmd(4'hE);
      if (s[0]) cmd(4'hF);
      if (s[1]) begin bus_sel = 1; cmd(4'h1); bus_sel = 0; end
      if (s[2]) cmd(4'h0);
      chk("R10 int sources", int_reg, s[2:0]);
      for (int m = 0; m < 8; m++) begin
        csr(2'd3, m[7:0]);
        chk("R10 irq masked", irq, |(s[2:0] & m[2:0]));
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule